// File: doc/BRIEF.md
# Serial fully connected inference engine

This block classifies one input vector with a fully connected network of two hidden layers and one output layer. A single multiply-accumulate datapath does all of the arithmetic, one product per clock. For every neuron of every layer, in order, it loads that neuron's bias into the accumulator, adds one weight-times-input product per cycle, and then spends one cycle on the result. A hidden-layer result is rectified, rescaled by an arithmetic right shift, clipped to the feature width and written to an activation bank. An output-layer result goes into a running signed maximum. Hidden activations alternate between two banks. The layer being computed reads from one bank and writes the other.

Features, weights and biases are held in on-chip stores. The stores are filled through a write-only load port while the state reset is high. Releasing the reset starts one inference on the next clock. When it ends, the engine raises a one-cycle done pulse and shows the index of the winning output neuron. It then stays idle until the next reset. Layer sizes, word widths and the rescale shift are parameters.

Top module: `fcn_serial_top`

## Requirements
- R1: While `state_rst` is high, `done` is low. After any reset, `class_idx` reads 0 until an inference produces a result.
- R2: A load write stores `ld_data` (low bits, two's complement) at `ld_addr` in the store chosen by `ld_tgt`: 0 for features, 1 for weights, 2 for biases. Weights are laid out layer by layer, with the first hidden layer at base 0. Inside a layer the address is neuron*fan_in + input. Biases are laid out layer by layer at layer base + neuron. No inference runs while reset is high.
- R3: Each neuron's accumulator starts at that neuron's sign-extended bias. With all weights zero, the class is decided by the output biases alone.
- R4: Each neuron adds the signed product of every incoming weight and the matching previous-layer value. For the first hidden layer that value is the input feature.
- R5: A hidden neuron with a negative sum stores 0. A non-negative sum is shifted right by SHIFT and clipped to the largest positive feature value.
- R6: Output neurons are not rectified. They are compared as signed sums, so the least negative sum can win.
- R7: When two output sums are equal, the lower neuron index wins.
- R8: `done` is high for exactly one cycle per inference. `class_idx` keeps its value from that cycle until the next reset.
- R9: `done` rises after exactly N_H1*(N_IN+2) + N_H2*(N_H1+2) + N_OUT*(N_H2+2) rising edges, counted from the first edge at which `state_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| state_rst | input | 1 | Synchronous active-high reset; an inference starts on the first edge after it goes low |
| ld_we | input | 1 | Load write strobe |
| ld_tgt | input | 2 | Load target: 0 features, 1 weights, 2 biases |
| ld_addr | input | LD_AW | Load address within the target store |
| ld_data | input | B_W | Load data, two's complement; low bits used for features and weights |
| done | output | 1 | One-cycle pulse marking a valid class |
| class_idx | output | CLS_W | Index of the winning output neuron |

## Verification
The checker watches, on every cycle, that the done pulse never lasts two cycles, that it never fires during reset or twice in one inference, that the reported class stays in range and is held after the pulse, and that no hidden activation written to a bank is negative. The bench alone can show the arithmetic: bias preload, product summation, rescale and clipping, the signed comparison of negative output sums, the lowest-index tie rule and the exact latency. It does this by comparing the class with a reference network computed in the bench, using directed cases and two random sweeps of a 4-3-3-2 network.

// File: rtl/fcn_pkg.sv
package fcn_pkg;

    localparam int CW = 16;

    typedef enum logic [1:0] {
        ST_BIAS = 2'd0,
        ST_MAC  = 2'd1,
        ST_POST = 2'd2,
        ST_HALT = 2'd3
    } phase_e;

    localparam logic [1:0] TGT_FEAT = 2'd0;
    localparam logic [1:0] TGT_WGT  = 2'd1;
    localparam logic [1:0] TGT_BIAS = 2'd2;

    typedef struct packed {
        phase_e          phase;
        logic [1:0]      layer;
        logic [CW-1:0]   neuron;
        logic [CW-1:0]   idx;
    } walk_t;

    function automatic int aw_of(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fcn_store.sv
module fcn_store #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int AW   = fcn_pkg::aw_of(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fcn_ctrl.sv
module fcn_ctrl
    import fcn_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_H1  = 6,
    parameter int N_H2  = 6,
    parameter int N_OUT = 4
) (
    input  logic  clk,
    input  logic  rst,
    output walk_t walk,
    output logic  last_post
);
    function automatic int fan_of(input logic [1:0] l);
        case (l)
            2'd0:    return N_IN;
            2'd1:    return N_H1;
            default: return N_H2;
        endcase
    endfunction

    function automatic int cnt_of(input logic [1:0] l);
        case (l)
            2'd0:    return N_H1;
            2'd1:    return N_H2;
            default: return N_OUT;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            walk <= '{phase: ST_BIAS, layer: 2'd0, neuron: '0, idx: '0};
        end else begin
            case (walk.phase)
                ST_BIAS: begin
                    walk.idx   <= '0;
                    walk.phase <= ST_MAC;
                end
                ST_MAC: begin
                    if (int'(walk.idx) == fan_of(walk.layer) - 1) begin
                        walk.phase <= ST_POST;
                    end else begin
                        walk.idx <= walk.idx + CW'(1);
                    end
                end
                ST_POST: begin
                    if (int'(walk.neuron) == cnt_of(walk.layer) - 1) begin
                        walk.neuron <= '0;
                        if (walk.layer == 2'd2) begin
                            walk.phase <= ST_HALT;
                        end else begin
                            walk.layer <= walk.layer + 2'd1;
                            walk.phase <= ST_BIAS;
                        end
                    end else begin
                        walk.neuron <= walk.neuron + CW'(1);
                        walk.phase  <= ST_BIAS;
                    end
                end
                default: ;
            endcase
        end
    end

    assign last_post = (walk.phase == ST_POST) && (walk.layer == 2'd2)
                       && (int'(walk.neuron) == N_OUT - 1);
endmodule

// File: rtl/fcn_mac.sv
module fcn_mac #(
    parameter int W_F   = 8,
    parameter int W_W   = 8,
    parameter int B_W   = 16,
    parameter int ACC_W = 20,
    localparam int PW   = W_F + W_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    init,
    input  logic                    step,
    input  logic [B_W-1:0]          bias,
    input  logic [W_F-1:0]          x,
    input  logic [W_W-1:0]          w,
    output logic signed [ACC_W-1:0] acc
);
    logic signed [PW-1:0] prod;

    assign prod = PW'($signed(x)) * PW'($signed(w));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (init) begin
            acc <= ACC_W'($signed(bias));
        end else if (step) begin
            acc <= acc + ACC_W'(prod);
        end
    end
endmodule

// File: rtl/fcn_relu_sat.sv
module fcn_relu_sat #(
    parameter int ACC_W = 20,
    parameter int W_F   = 8,
    parameter int SHIFT = 4
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic [W_F-1:0]          act
);
    localparam logic signed [ACC_W-1:0] TOP = ACC_W'((1 << (W_F - 1)) - 1);

    logic signed [ACC_W-1:0] shifted;

    always_comb begin
        shifted = acc >>> SHIFT;
        if (acc[ACC_W-1]) begin
            act = '0;
        end else if (shifted > TOP) begin
            act = TOP[W_F-1:0];
        end else begin
            act = shifted[W_F-1:0];
        end
    end
endmodule

// File: rtl/fcn_argmax.sv
module fcn_argmax #(
    parameter int ACC_W = 20,
    parameter int CLS_W = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    first,
    input  logic [CLS_W-1:0]        idx,
    input  logic signed [ACC_W-1:0] sum,
    output logic [CLS_W-1:0]        best_idx
);
    logic signed [ACC_W-1:0] best_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            best_val <= '0;
            best_idx <= '0;
        end else if (en && (first || (sum > best_val))) begin
            best_val <= sum;
            best_idx <= idx;
        end
    end
endmodule

// File: rtl/fcn_serial_top.sv
module fcn_serial_top
    import fcn_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_H1  = 6,
    parameter int N_H2  = 6,
    parameter int N_OUT = 4,
    parameter int W_F   = 8,
    parameter int W_W   = 8,
    parameter int B_W   = 16,
    parameter int SHIFT = 4,
    localparam int N_WGT  = N_IN * N_H1 + N_H1 * N_H2 + N_H2 * N_OUT,
    localparam int N_BIAS = N_H1 + N_H2 + N_OUT,
    localparam int LD_AW  = $clog2(N_WGT),
    localparam int CLS_W  = $clog2(N_OUT)
) (
    input  logic             clk,
    input  logic             state_rst,
    input  logic             ld_we,
    input  logic [1:0]       ld_tgt,
    input  logic [LD_AW-1:0] ld_addr,
    input  logic [B_W-1:0]   ld_data,
    output logic             done,
    output logic [CLS_W-1:0] class_idx
);
    localparam int MAX_FAN = max3(N_IN, N_H1, N_H2);
    localparam int HMAX    = (N_H1 > N_H2) ? N_H1 : N_H2;
    localparam int ACC_W   = W_F + W_W + $clog2(MAX_FAN + 1);
    localparam int F_AW    = aw_of(N_IN);
    localparam int W_AW    = aw_of(N_WGT);
    localparam int B_AW    = aw_of(N_BIAS);
    localparam int H_AW    = aw_of(HMAX);
    localparam int OFS_W2  = N_IN * N_H1;
    localparam int OFS_W3  = N_IN * N_H1 + N_H1 * N_H2;

    walk_t walk;
    logic  last_post;

    fcn_ctrl #(.N_IN(N_IN), .N_H1(N_H1), .N_H2(N_H2), .N_OUT(N_OUT)) ctrl_i (
        .clk       (clk),
        .rst       (state_rst),
        .walk      (walk),
        .last_post (last_post)
    );

    // address generation for the layer-ordered parameter stores
    logic [W_AW-1:0] w_raddr;
    logic [B_AW-1:0] b_raddr;

    always_comb begin
        case (walk.layer)
            2'd0: begin
                w_raddr = W_AW'(int'(walk.neuron) * N_IN + int'(walk.idx));
                b_raddr = B_AW'(int'(walk.neuron));
            end
            2'd1: begin
                w_raddr = W_AW'(OFS_W2 + int'(walk.neuron) * N_H1 + int'(walk.idx));
                b_raddr = B_AW'(N_H1 + int'(walk.neuron));
            end
            default: begin
                w_raddr = W_AW'(OFS_W3 + int'(walk.neuron) * N_H2 + int'(walk.idx));
                b_raddr = B_AW'(N_H1 + N_H2 + int'(walk.neuron));
            end
        endcase
    end

    logic [W_F-1:0] feat_rd;
    logic [W_W-1:0] wgt_rd;
    logic [B_W-1:0] bias_rd;

    fcn_store #(.DEPTH(N_IN), .W(W_F)) feat_i (
        .clk   (clk),
        .we    (ld_we && (ld_tgt == TGT_FEAT)),
        .waddr (ld_addr[F_AW-1:0]),
        .wdata (ld_data[W_F-1:0]),
        .raddr (F_AW'(walk.idx)),
        .rdata (feat_rd)
    );

    fcn_store #(.DEPTH(N_WGT), .W(W_W)) wgt_i (
        .clk   (clk),
        .we    (ld_we && (ld_tgt == TGT_WGT)),
        .waddr (ld_addr[W_AW-1:0]),
        .wdata (ld_data[W_W-1:0]),
        .raddr (w_raddr),
        .rdata (wgt_rd)
    );

    fcn_store #(.DEPTH(N_BIAS), .W(B_W)) bias_i (
        .clk   (clk),
        .we    (ld_we && (ld_tgt == TGT_BIAS)),
        .waddr (ld_addr[B_AW-1:0]),
        .wdata (ld_data),
        .raddr (b_raddr),
        .rdata (bias_rd)
    );

    // ping-pong activation banks: layer 0 writes bank 0, layer 1 writes bank 1
    logic           act_we;
    logic [W_F-1:0] act_wdata;
    logic [W_F-1:0] act_rd [2];

    assign act_we = (walk.phase == ST_POST) && (walk.layer != 2'd2);

    for (genvar b = 0; b < 2; b++) begin : g_bank
        fcn_store #(.DEPTH(HMAX), .W(W_F)) bank_i (
            .clk   (clk),
            .we    (act_we && (walk.layer[0] == 1'(b))),
            .waddr (H_AW'(walk.neuron)),
            .wdata (act_wdata),
            .raddr (H_AW'(walk.idx)),
            .rdata (act_rd[b])
        );
    end

    logic [W_F-1:0] x_sel;
    assign x_sel = (walk.layer == 2'd0) ? feat_rd
                 : (walk.layer[0] ? act_rd[0] : act_rd[1]);

    logic signed [ACC_W-1:0] acc;

    fcn_mac #(.W_F(W_F), .W_W(W_W), .B_W(B_W), .ACC_W(ACC_W)) mac_i (
        .clk  (clk),
        .rst  (state_rst),
        .init (walk.phase == ST_BIAS),
        .step (walk.phase == ST_MAC),
        .bias (bias_rd),
        .x    (x_sel),
        .w    (wgt_rd),
        .acc  (acc)
    );

    fcn_relu_sat #(.ACC_W(ACC_W), .W_F(W_F), .SHIFT(SHIFT)) relu_i (
        .acc (acc),
        .act (act_wdata)
    );

    fcn_argmax #(.ACC_W(ACC_W), .CLS_W(CLS_W)) argmax_i (
        .clk      (clk),
        .rst      (state_rst),
        .en       ((walk.phase == ST_POST) && (walk.layer == 2'd2)),
        .first    (walk.neuron == '0),
        .idx      (CLS_W'(walk.neuron)),
        .sum      (acc),
        .best_idx (class_idx)
    );

    always_ff @(posedge clk) begin
        if (state_rst) begin
            done <= 1'b0;
        end else begin
            done <= last_post;
        end
    end
endmodule

// File: rtl/fcn_serial_chk.sv
module fcn_serial_chk #(
    parameter int N_OUT = 4,
    parameter int CLS_W = 2,
    parameter int W_F   = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             done,
    input logic [CLS_W-1:0] class_idx,
    input logic             act_we,
    input logic [W_F-1:0]   act_wdata
);
    logic seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 1'b0;
        end else if (done) begin
            seen <= 1'b1;
        end
    end

    p_quiet_in_reset_r1: assert property (@(posedge clk) rst |=> !done);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_once_r8: assert property (@(posedge clk) disable iff (rst)
        seen |-> !done);

    p_class_hold_r8: assert property (@(posedge clk) disable iff (rst)
        seen |-> $stable(class_idx));

    p_class_range_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (32'(class_idx) < N_OUT));

    p_act_nonneg_r5: assert property (@(posedge clk) disable iff (rst)
        act_we |-> !act_wdata[W_F-1]);
endmodule

bind fcn_serial_top fcn_serial_chk #(.N_OUT(N_OUT), .CLS_W(CLS_W), .W_F(W_F)) chk_i (
    .clk       (clk),
    .rst       (state_rst),
    .done      (done),
    .class_idx (class_idx),
    .act_we    (act_we),
    .act_wdata (act_wdata)
);

// File: tb/fcn_serial_top_tb_top.sv
module fcn_serial_top_tb_top;
    localparam int NI = 4, NH1 = 3, NH2 = 3, NO = 2;
    localparam int WF = 8, WW = 8, BW = 16, SH = 2;
    localparam int NW  = NI * NH1 + NH1 * NH2 + NH2 * NO;
    localparam int NB  = NH1 + NH2 + NO;
    localparam int LAW = $clog2(NW);
    localparam int CLW = $clog2(NO);
    localparam int LAT = NH1 * (NI + 2) + NH2 * (NH1 + 2) + NO * (NH2 + 2);
    localparam int FMAX = (1 << (WF - 1)) - 1;

    logic           clk = 1'b0;
    logic           state_rst = 1'b1;
    logic           ld_we = 1'b0;
    logic [1:0]     ld_tgt = 2'd0;
    logic [LAW-1:0] ld_addr = '0;
    logic [BW-1:0]  ld_data = '0;
    logic           done;
    logic [CLW-1:0] class_idx;

    always #10 clk = ~clk;

    fcn_serial_top #(
        .N_IN(NI), .N_H1(NH1), .N_H2(NH2), .N_OUT(NO),
        .W_F(WF), .W_W(WW), .B_W(BW), .SHIFT(SH)
    ) dut_i (
        .clk       (clk),
        .state_rst (state_rst),
        .ld_we     (ld_we),
        .ld_tgt    (ld_tgt),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .done      (done),
        .class_idx (class_idx)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int feat [NI];
    int wt [NW];
    int bs [NB];

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int wi1(input int n, input int i); return n * NI + i; endfunction
    function automatic int wi2(input int n, input int i); return NI * NH1 + n * NH1 + i; endfunction
    function automatic int wi3(input int n, input int i); return NI * NH1 + NH1 * NH2 + n * NH2 + i; endfunction
    function automatic int bi2(input int n); return NH1 + n; endfunction
    function automatic int bi3(input int n); return NH1 + NH2 + n; endfunction

    function automatic int rect(input int a);
        int s;
        if (a < 0) return 0;
        s = a >>> SH;
        return (s > FMAX) ? FMAX : s;
    endfunction

    function automatic int ref_class();
        int h1 [NH1];
        int h2 [NH2];
        int acc, best, bv;
        for (int n = 0; n < NH1; n++) begin
            acc = bs[n];
            for (int i = 0; i < NI; i++) acc += wt[wi1(n, i)] * feat[i];
            h1[n] = rect(acc);
        end
        for (int n = 0; n < NH2; n++) begin
            acc = bs[bi2(n)];
            for (int i = 0; i < NH1; i++) acc += wt[wi2(n, i)] * h1[i];
            h2[n] = rect(acc);
        end
        best = 0;
        bv = 0;
        for (int n = 0; n < NO; n++) begin
            acc = bs[bi3(n)];
            for (int i = 0; i < NH2; i++) acc += wt[wi3(n, i)] * h2[i];
            if (n == 0 || acc > bv) begin
                bv = acc;
                best = n;
            end
        end
        return best;
    endfunction

    task automatic clear_all();
        for (int i = 0; i < NI; i++) feat[i] = 0;
        for (int i = 0; i < NW; i++) wt[i] = 0;
        for (int i = 0; i < NB; i++) bs[i] = 0;
    endtask

    task automatic wr(input logic [1:0] t, input int a, input int v);
        ld_we   = 1'b1;
        ld_tgt  = t;
        ld_addr = LAW'(a);
        ld_data = BW'(v);
        @(negedge clk);
    endtask

    task automatic run_trial(input string req);
        int cyc;
        int highs;
        bit got;
        int cls;
        state_rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NI; i++) wr(2'd0, i, feat[i]);
        for (int i = 0; i < NW; i++) wr(2'd1, i, wt[i]);
        for (int i = 0; i < NB; i++) wr(2'd2, i, bs[i]);
        ld_we = 1'b0;
        check("R2", "done while loading in reset", int'(done), 0);
        state_rst = 1'b0;
        cyc = 0;
        got = 1'b0;
        while (!got && cyc < LAT + 20) begin
            @(negedge clk);
            cyc++;
            if (done) got = 1'b1;
        end
        check("R9", "cycles to done", cyc, LAT);
        cls = int'(class_idx);
        check(req, "class", cls, ref_class());
        highs = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (done) highs++;
            if (int'(class_idx) != cls) highs += 100;
        end
        check("R8", "done repeats or class moves after pulse", highs, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R9 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "done in reset", int'(done), 0);
        check("R1", "class after reset", int'(class_idx), 0);

        // R3: zero weights, the output biases alone decide
        clear_all();
        bs[bi3(0)] = 5;
        bs[bi3(1)] = 9;
        feat[0] = 40;
        run_trial("R3");
        check("R3", "bias-only winner", int'(class_idx), 1);

        // R7: equal output sums, lowest index wins
        clear_all();
        bs[bi3(0)] = 7;
        bs[bi3(1)] = 7;
        run_trial("R7");
        check("R7", "tie winner", int'(class_idx), 0);

        // R6: both output sums negative, least negative wins
        clear_all();
        bs[bi3(0)] = -50;
        bs[bi3(1)] = -20;
        run_trial("R6");
        check("R6", "signed output compare", int'(class_idx), 1);

        // R5: negative hidden sums must become zero
        clear_all();
        for (int n = 0; n < NH1; n++) bs[n] = -400;
        for (int n = 0; n < NH2; n++)
            for (int i = 0; i < NH1; i++) wt[wi2(n, i)] = -1;
        bs[bi3(0)] = 10;
        for (int i = 0; i < NH2; i++) wt[wi3(1, i)] = 1;
        run_trial("R5");
        check("R5", "rectified hidden layer", int'(class_idx), 0);

        // R5: large positive sums clip to the feature maximum
        clear_all();
        for (int i = 0; i < NI; i++) feat[i] = 127;
        for (int n = 0; n < NH1; n++)
            for (int i = 0; i < NI; i++) wt[wi1(n, i)] = 127;
        for (int n = 0; n < NH2; n++)
            for (int i = 0; i < NH1; i++) wt[wi2(n, i)] = 1;
        bs[bi3(0)] = 50;
        for (int i = 0; i < NH2; i++) wt[wi3(1, i)] = 1;
        run_trial("R5");
        check("R5", "saturated hidden layer", int'(class_idx), 1);

        // R4: feature order matters, first layer picks one feature per neuron
        clear_all();
        feat[0] = 100;
        feat[1] = 4;
        wt[wi1(0, 0)] = 1;
        wt[wi1(1, 1)] = 1;
        wt[wi2(0, 0)] = 1;
        wt[wi2(1, 1)] = 1;
        wt[wi3(0, 0)] = 1;
        wt[wi3(1, 1)] = 1;
        run_trial("R4");
        check("R4", "feature 0 dominates", int'(class_idx), 0);
        feat[0] = 4;
        feat[1] = 100;
        run_trial("R4");
        check("R4", "feature 1 dominates", int'(class_idx), 1);

        // R4: sweep with small weights
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < NI; i++) feat[i] = int'($urandom_range(60)) - 30;
            for (int i = 0; i < NW; i++) wt[i] = int'($urandom_range(15)) - 8;
            for (int i = 0; i < NB; i++) bs[i] = int'($urandom_range(200)) - 100;
            run_trial("R4");
        end

        // R4 and R5: sweep with full-range values
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < NI; i++) feat[i] = int'($urandom_range(255)) - 128;
            for (int i = 0; i < NW; i++) wt[i] = int'($urandom_range(255)) - 128;
            for (int i = 0; i < NB; i++) bs[i] = int'($urandom_range(20000)) - 10000;
            run_trial("R4");
        end

        state_rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "class after final reset", int'(class_idx), 0);
        check("R1", "done after final reset", int'(done), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule